// File: doc/BRIEF.md
# Nearest-Odd-Point Slicing Divider

This block takes a signed fixed-point residual (the dividend) and a signed diagonal gain (the divisor). It returns the odd integer nearest to their ratio, clipped to the Q-PAM alphabet {±1, ±3, …, ±(Q−1)}. The alphabet size follows a run-time mode input, so one instance can serve 4-, 16- and 64-QAM. The block never forms a full quotient. It works on the magnitudes of the operands and runs log2(Q) restoring shift-and-subtract steps. On the first step the shifted divisor is compared against the dividend. Each later step compares it against the previous remainder, with the shift falling by one per step. Each step yields one bit of the result, most significant bit first.

Besides the point, the block reports which side of the exact ratio the chosen point lies on. A tree-search engine uses this to pick the next candidate on the other side. A request is a single-cycle `start` carrying all operands. The answer arrives with a one-cycle `done` pulse a fixed, mode-dependent number of cycles later.

Top module: `odd_slicer`

## Requirements
- R1: When `done` is high, `point` (two's complement, LOG_QMAX+1 bits) holds the odd integer nearest to dividend/divisor, among the odd values of magnitude up to Q−1.
- R2: A ratio beyond the alphabet gives the outermost point of matching sign: |point| never exceeds Q−1.
- R3: `mode` selects the alphabet: 0 gives Q=2, 1 gives Q=4, 2 gives Q=8, and 3 behaves like 2. The step count L is log2(Q).
- R4: A request accepted in cycle c produces a one-cycle `done` in cycle c+L. `busy` is high in cycles c+1 … c+L−1 and never together with `done`.
- R5: The sign of `point` is the XOR of the operand sign bits, and its magnitude comes from the operand magnitudes. A zero dividend therefore gives +1 for a positive divisor and −1 for a negative one.
- R6: `rnd_up` is 1 exactly when `point` is strictly greater than the exact ratio. It is 0 when the point lies below the ratio or equals it.
- R7: A ratio that is exactly an even integer inside the alphabet resolves to the neighbouring odd value of larger magnitude.
- R8: While `busy` is high, `start`, the operands and `mode` have no effect on the result in flight.
- R9: `point` and `rnd_up` keep their value between `done` pulses. After reset they are +1 and 0, with `done` and `busy` low.
- R10: A zero divisor gives `point` = +1 and `rnd_up` = 0 in every mode.
- R11: A `start` in the cycle where `done` is high is accepted, so requests can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when not busy |
| dividend | input | W | Signed residual value |
| divisor | input | W | Signed diagonal gain |
| mode | input | MODE_W | Alphabet select (see R3) |
| busy | output | 1 | A request is in its inner steps |
| done | output | 1 | One-cycle pulse: result valid |
| point | output | LOG_QMAX+1 | Signed odd constellation point |
| rnd_up | output | 1 | Point lies above the exact ratio |

## Verification
Completing one request and accepting the next can fall in the same cycle. The last subtraction step registers the answer at the same edge where a fresh `start` loads new operands, and for the 2-point alphabet that request also finishes at once. The bench drives `start` again in the `done` cycle, first with a one-step request and then with requests of every depth. It checks that the first answer is intact and that the second appears exactly L cycles later with its own expected value. Requests carrying noise on every input while busy check that the pending result is not disturbed.

// File: rtl/nos_pkg.sv
package nos_pkg;

  // Number of subtraction steps for a mode code, clipped to the deepest alphabet.
  function automatic int unsigned depth_for_mode(input int unsigned mode_code,
                                                 input int unsigned max_depth);
    int unsigned d;
    d = mode_code + 1;
    if (d > max_depth) d = max_depth;
    return d;
  endfunction

endpackage

// File: rtl/nos_seq.sv
module nos_seq
  import nos_pkg::*;
#(
  parameter int LOG_QMAX = 3,
  parameter int MODE_W   = 2,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  output logic              accept,
  output logic              active,
  output logic              last,
  output logic              busy,
  output logic [CNT_W-1:0]  shamt,
  output logic [CNT_W-1:0]  depth_now
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    depth_now = CNT_W'(depth_for_mode(32'(mode), LOG_QMAX));
    accept    = start & ~busy_q;
    active    = accept | busy_q;
    shamt     = accept ? (depth_now - CNT_W'(1)) : cnt_q;
    last      = active & (shamt == '0);
  end

  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= active & ~last;
      if (active & ~last) cnt_q <= shamt - CNT_W'(1);
    end
  end

  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) last |=> !busy); // R4
  AST_BUSY_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(active)) |-> (shamt < $past(shamt))); // R4

endmodule

// File: rtl/nos_step.sv
module nos_step #(
  parameter int DIV_W = 14,
  parameter int ACC_W = 17,
  parameter int CNT_W = 2
) (
  input  logic [DIV_W-1:0] rem_in,
  input  logic [DIV_W-1:0] dsr,
  input  logic [CNT_W-1:0] shamt,
  output logic             take,
  output logic [DIV_W-1:0] rem_out
);

  function automatic logic [ACC_W-1:0] scaled(input logic [DIV_W-1:0] d,
                                               input logic [CNT_W-1:0] sh);
    return ACC_W'(d) << sh;
  endfunction

  logic [ACC_W-1:0] trial;

  always_comb begin
    trial   = scaled(dsr, shamt);
    take    = (trial <= ACC_W'(rem_in));
    rem_out = take ? (rem_in - trial[DIV_W-1:0]) : rem_in;
  end

endmodule

// File: rtl/nos_map.sv
module nos_map #(
  parameter int LOG_QMAX = 3
) (
  input  logic [LOG_QMAX-1:0] qbits,
  input  logic                neg,
  input  logic                zdiv,
  input  logic                exact,
  output logic signed [LOG_QMAX:0] point,
  output logic                rnd_up
);

  function automatic logic signed [LOG_QMAX:0] odd_of(input logic [LOG_QMAX-1:0] q);
    return {1'b0, q[LOG_QMAX-1:1], 1'b1};
  endfunction

  logic signed [LOG_QMAX:0] mag;

  always_comb begin
    mag = odd_of(qbits);
    if (zdiv) begin
      point  = (LOG_QMAX+1)'(1);
      rnd_up = 1'b0;
    end else if (neg) begin
      point  = -mag;
      rnd_up = qbits[0] & ~exact;
    end else begin
      point  = mag;
      rnd_up = ~qbits[0];
    end
  end

endmodule

// File: rtl/odd_slicer.sv
module odd_slicer
  import nos_pkg::*;
#(
  parameter int W        = 14,
  parameter int LOG_QMAX = 3,
  parameter int MODE_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [W-1:0]      dividend,
  input  logic signed [W-1:0]      divisor,
  input  logic [MODE_W-1:0]        mode,
  output logic                     busy,
  output logic                     done,
  output logic signed [LOG_QMAX:0] point,
  output logic                     rnd_up
);

  localparam int SYM_W = LOG_QMAX + 1;
  localparam int CNT_W = $clog2(LOG_QMAX + 1);
  localparam int ACC_W = W + LOG_QMAX;

  function automatic logic [W-1:0] magnitude(input logic signed [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  // sequencing
  logic             accept, active, last;
  logic [CNT_W-1:0] shamt, depth_now;

  nos_seq #(.LOG_QMAX(LOG_QMAX), .MODE_W(MODE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .accept(accept), .active(active), .last(last), .busy(busy),
    .shamt(shamt), .depth_now(depth_now)
  );

  // operand state
  logic [W-1:0]        rem_q, dsr_q;
  logic [LOG_QMAX-1:0] q_q;
  logic                neg_q, zdiv_q;
  logic [CNT_W-1:0]    lat_q;

  // first-step multiplexer: live operands on accept, stored state afterwards
  logic [W-1:0]        rem_in, dsr_in, rem_out;
  logic [LOG_QMAX-1:0] q_prev, q_next;
  logic                neg_in, zdiv_in, take;

  always_comb begin
    rem_in  = accept ? magnitude(dividend) : rem_q;
    dsr_in  = accept ? magnitude(divisor) : dsr_q;
    neg_in  = accept ? (dividend[W-1] ^ divisor[W-1]) : neg_q;
    zdiv_in = accept ? (divisor == '0) : zdiv_q;
    q_prev  = accept ? '0 : q_q;
    q_next  = {q_prev[LOG_QMAX-2:0], take};
  end

  nos_step #(.DIV_W(W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_step (
    .rem_in(rem_in), .dsr(dsr_in), .shamt(shamt),
    .take(take), .rem_out(rem_out)
  );

  logic signed [SYM_W-1:0] point_c;
  logic                    up_c;

  nos_map #(.LOG_QMAX(LOG_QMAX)) u_map (
    .qbits(q_next), .neg(neg_in), .zdiv(zdiv_in), .exact(rem_out == '0),
    .point(point_c), .rnd_up(up_c)
  );

  logic                    done_q, up_q;
  logic signed [SYM_W-1:0] point_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      dsr_q   <= '0;
      q_q     <= '0;
      neg_q   <= 1'b0;
      zdiv_q  <= 1'b0;
      lat_q   <= '0;
      done_q  <= 1'b0;
      point_q <= SYM_W'(1);
      up_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        dsr_q  <= dsr_in;
        neg_q  <= neg_in;
        zdiv_q <= zdiv_in;
        lat_q  <= depth_now;
      end
      if (active & ~last) begin
        rem_q <= rem_out;
        q_q   <= q_next;
      end
      if (last) begin
        point_q <= point_c;
        up_q    <= up_c;
      end
    end
  end

  assign done   = done_q;
  assign point  = point_q;
  assign rnd_up = up_q;

  // observation wires for the assertions
  logic [CNT_W-1:0] busy_cnt;
  logic [SYM_W-1:0] point_mag, point_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (accept) busy_cnt <= '0;
    else if (busy)   busy_cnt <= busy_cnt + CNT_W'(1);
  end

  assign point_mag = point_q[SYM_W-1] ? SYM_W'(-point_q) : SYM_W'(point_q);
  assign point_lim = (SYM_W'(1) << lat_q) - SYM_W'(1);

  AST_POINT_ODD: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> point_q[0]); // R1
  AST_POINT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> (point_mag <= point_lim)); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> (busy_cnt == lat_q - CNT_W'(1))); // R4
  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !done_q); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(lat_q)); // R8
  AST_POINT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_q |-> ($stable(point_q) && $stable(up_q))); // R9
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n) (done_q && zdiv_q) |-> (point_q == SYM_W'(1) && !up_q)); // R10

endmodule

// File: tb/odd_slicer_bench.sv
`timescale 1ns/1ps
module odd_slicer_bench;

  localparam int W = 14;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic signed [W-1:0] dividend = '0;
  logic signed [W-1:0] divisor = '0;
  logic [1:0]          mode = '0;
  logic                busy, done, rnd_up;
  logic signed [3:0]   point;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  odd_slicer #(.W(W), .LOG_QMAX(3), .MODE_W(2)) u_odd_slicer (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .mode(mode), .busy(busy), .done(done), .point(point), .rnd_up(rnd_up)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int depth_of(input int md);
    return (md >= 2) ? 3 : md + 1;
  endfunction

  // nearest odd point by exhaustive distance search over the alphabet
  function automatic void model(input int a, input int b, input int md, output int s, output bit up);
    int q, best, bestd, d, e;
    q = 1 << depth_of(md);
    if (b == 0) begin
      s = 1; up = 1'b0; return;
    end
    if (a == 0) best = (b < 0) ? -1 : 1;
    else begin
      bestd = 32'h7fffffff; best = 1;
      for (int c = -(q - 1); c <= q - 1; c += 2) begin
        d = a - c * b;
        if (d < 0) d = -d;
        if (d < bestd || (d == bestd && (c < 0 ? -c : c) > (best < 0 ? -best : best))) begin
          bestd = d; best = c;
        end
      end
    end
    e = best * b - a;
    up = (b > 0) ? (e > 0) : (e < 0);
    s = best;
  endfunction

  task automatic run_op(input int a, input int b, input int md, input bit noisy,
                        input bit hold, input string req);
    int es, n, lat;
    bit eu, seen;
    model(a, b, md, es, eu);
    lat = depth_of(md);
    @(negedge clk);
    start = 1'b1; dividend = W'(a); divisor = W'(b); mode = 2'(md);
    seen = 1'b0; n = 0;
    for (int i = 1; i <= 8 && !seen; i++) begin
      @(negedge clk);
      n = i;
      if (done) begin
        seen = 1'b1;
        start = 1'b0;
      end else if (noisy) begin
        start = 1'b1;
        dividend = W'($urandom);
        divisor = W'($urandom);
        mode = 2'($urandom);
      end else begin
        start = 1'b0;
      end
    end
    chk(seen && n == lat, "R4", "done latency", n, lat);
    chk(int'(point) == es, req, "point", int'(point), es);
    chk(rnd_up == eu, "R6", "rnd_up", int'(rnd_up), int'(eu));
    if (hold) begin
      @(negedge clk);
      chk(!done && int'(point) == es && rnd_up == eu, "R9", "held point", int'(point), es);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (300) @(posedge clk);
    while (!finished) begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
        finished = 1'b1;
        chk(1'b0, "R4", "watchdog expired", 0, 1);
        summary();
        $finish;
      end
    end
  end

  initial begin
    int a, b, md, k, es0, es1;
    bit eu0, eu1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R9", "reset done/busy", int'(done) + int'(busy), 0);
    chk(int'(point) == 1 && !rnd_up, "R9", "reset point", int'(point), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nearest odd in each mode
    run_op(700, 100, 2, 1'b0, 1'b1, "R1");   // 7.0 -> 7
    run_op(450, 100, 2, 1'b0, 1'b0, "R1");   // 4.5 -> 5
    run_op(250, 100, 1, 1'b0, 1'b0, "R1");   // 2.5 -> 3
    run_op(90, 100, 0, 1'b0, 1'b0, "R1");    // 0.9 -> 1
    // R2: saturation both signs
    run_op(8000, 3, 2, 1'b0, 1'b0, "R2");
    run_op(-8000, 3, 1, 1'b0, 1'b0, "R2");
    run_op(-8192, -1, 2, 1'b0, 1'b0, "R2");
    run_op(8191, -8192, 0, 1'b0, 1'b0, "R2");
    // R3: mode 3 behaves as mode 2
    run_op(610, 100, 3, 1'b0, 1'b0, "R3");
    run_op(610, 100, 1, 1'b0, 1'b0, "R3");
    // R5: signs and zero dividend
    run_op(-330, 100, 2, 1'b0, 1'b0, "R5");
    run_op(330, -100, 2, 1'b0, 1'b0, "R5");
    run_op(-330, -100, 2, 1'b0, 1'b0, "R5");
    run_op(0, 77, 1, 1'b0, 1'b0, "R5");
    run_op(0, -77, 2, 1'b0, 1'b0, "R5");
    // R6: exact odd ratio sits on the point, neither side
    run_op(-500, 100, 2, 1'b0, 1'b0, "R6");
    run_op(300, 100, 1, 1'b0, 1'b0, "R6");
    // R7: even ratios go outward
    run_op(200, 100, 2, 1'b0, 1'b0, "R7");
    run_op(-400, 100, 2, 1'b0, 1'b0, "R7");
    run_op(600, -100, 2, 1'b0, 1'b0, "R7");
    // R10: zero divisor
    run_op(1234, 0, 2, 1'b0, 1'b1, "R10");
    run_op(-1234, 0, 0, 1'b0, 1'b0, "R10");
    // R8: noise on every input while busy
    run_op(-380, 60, 2, 1'b1, 1'b1, "R8");
    run_op(150, -50, 1, 1'b1, 1'b0, "R8");

    // R11: start again in the done cycle, one-step requests
    model(10, 4, 0, es0, eu0);
    model(-9, 2, 0, es1, eu1);
    @(negedge clk);
    start = 1'b1; dividend = 14'sd10; divisor = 14'sd4; mode = 2'd0;
    @(negedge clk);
    chk(done && int'(point) == es0, "R11", "first point", int'(point), es0);
    dividend = -14'sd9; divisor = 14'sd2;
    @(negedge clk);
    chk(done && int'(point) == es1 && rnd_up == eu1, "R11", "second point", int'(point), es1);
    start = 1'b0;
    @(negedge clk);

    // R11: back-to-back with deeper requests
    for (int i = 0; i < 12; i++) begin
      md = i % 4;
      a = int'($urandom_range(0, 4000)) - 2000;
      b = int'($urandom_range(1, 600));
      run_op(a, b, md, 1'b0, 1'b0, "R11");
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      md = int'($urandom % 4);
      if (i % 10 == 0) begin
        a = int'($urandom_range(0, 16383)) - 8192;
        b = int'($urandom_range(0, 16383)) - 8192;
      end else begin
        k = int'($urandom_range(0, 20)) - 10;
        b = int'($urandom_range(0, 2047)) - 1024;
        a = (k * b) / 2 + int'($urandom_range(0, 1024)) - 512;
      end
      run_op(a, b, md, (md != 0) && (i % 3 == 0), (i % 5 == 0), "R1");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule